// File: doc/BRIEF.md
# Self-Timed Two-Mode SRAM Access Sequencer

This block runs one memory access each time a cycle-start strobe is accepted. The access starts with an evaluation phase and ends with a balance phase. The evaluation phase begins at the strobe. It ends when a replica voltage monitor reports completion, or when a tick limit runs out. The balance phase then fills the rest of the cycle. The monitor uses a read threshold or a write threshold. The sequencer drives a mode select that picks between them, so one completion input closes evaluation in either mode.

The two modes drive different signals:
- In a write, the sequencer raises the addressed word line and the evaluate line of the addressed column.
- In a read, evaluate stays low. The addressed word line and the dummy word line rise instead.
- Only writes produce a cell-erase pulse, and its width is a fixed number of ticks.

All logic runs on one fast internal clock, and the completion input is synchronized to it. Mode and address are captured when a strobe is accepted and held for the whole access.

Top module: `sram_selftime_ctrl`

## Requirements
- R1: After reset, `gate` is 0, `gate_n` is 1, `eq` is 1, and `wl`, `ev`, `dwl`, `erase` and `timeout` are all 0.
- R2: A `cyc_start` sampled high while `gate` is 0 sets `gate` to 1 and `eq` to 0 at that clock edge. `gate_n` is always the inverse of `gate`, and `eq` is the inverse of `gate`.
- R3: In a write access (`wr_en` = 1 at the accepted strobe), for as long as `gate` is 1: `wl` has only bit `row_addr` set, `ev` has only bit `col_addr` set, and `dwl` is 0.
- R4: In a read access (`wr_en` = 0 at the accepted strobe), for as long as `gate` is 1: `ev` is all zero, `wl` has only bit `row_addr` set, and `dwl` is 1.
- R5: `mon_sel` equals the captured `wr_en` (1 = write threshold). `mon_sel`, `wl` and `ev` do not change during an access, whatever the mode and address inputs do.
- R6: A write raises `erase` at the start edge and holds it for exactly ERASE_TICKS clock cycles. A read produces no `erase`.
- R7: A rising edge of `done_in` ends evaluation. If `done_in` is first high at clock edge a, then at edge a+2 `gate` falls, `eq` rises, and `wl`, `ev` and `dwl` drop to 0. `timeout` is 0 after such an access.
- R8: If no completion arrives, evaluation ends after TMO_TICKS cycles with `gate` high and `timeout` is set. If completion and the limit fall on the same edge, completion wins. `timeout` holds until the next accepted strobe clears it.
- R9: A `cyc_start` that arrives while `gate` is 1 is ignored. A `done_in` pulse while `gate` is 0 changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast internal clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_start | input | 1 | Access start strobe |
| wr_en | input | 1 | 1 = write access, 0 = read access |
| row_addr | input | $clog2(ROWS) | Row address |
| col_addr | input | $clog2(COLS) | Column address |
| done_in | input | 1 | Asynchronous completion from the replica monitor |
| gate | output | 1 | Gate-timing signal, high during evaluation |
| gate_n | output | 1 | Inverse of `gate` |
| eq | output | 1 | Equalize (balance) enable |
| ev | output | COLS | Per-column evaluate enables |
| wl | output | ROWS | Word-line enables |
| dwl | output | 1 | Dummy word-line enable |
| erase | output | 1 | Cell-erase pulse |
| mon_sel | output | 1 | Monitor threshold select, 1 = write |
| timeout | output | 1 | Last evaluation ended by the tick limit |

## Verification
The assertions assume the following about the inputs:
- Addresses stay within ROWS and COLS.
- Every completion pulse lasts at least two clock cycles, so the synchronizer sees it.
- `done_in` returns low before the next access.

Given those assumptions, the assertions expect evaluation to be bounded by the tick limit and the decoded enables to stay one-hot. The stimulus holds each completion pulse for two cycles and waits several idle cycles after each access. It draws addresses below ROWS and COLS. It fires strobes and completions at random points, including strobes in the middle of an access and completions while idle.

// File: rtl/sram_st_pkg.sv
package sram_st_pkg;
  // stages of synchronizer ahead of the edge detector
  localparam int SYNC_STAGES = 2;

  typedef enum logic {
    MODE_READ  = 1'b0,
    MODE_WRITE = 1'b1
  } acc_mode_e;
endpackage

// File: rtl/sst_done_sync.sv
module sst_done_sync
  import sram_st_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic done_in,
  output logic done_rise
);
  localparam int SH_W = SYNC_STAGES + 1;

  logic [SH_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[SH_W-2:0], done_in};
  end

  assign done_rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
endmodule

// File: rtl/sst_phase_ctrl.sv
module sst_phase_ctrl #(
  parameter int TMO_TICKS = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic cyc_start,
  input  logic done_rise,
  output logic gate,
  output logic start_acc,
  output logic end_acc,
  output logic timeout
);
  localparam int CW = $clog2(TMO_TICKS + 1);
  localparam logic [CW-1:0] LAST_TICK = CW'(TMO_TICKS - 1);

  logic [CW-1:0] tick_q;
  logic          tmo_hit;

  assign start_acc = cyc_start & ~gate;
  assign tmo_hit   = gate & (tick_q == LAST_TICK) & ~done_rise;
  assign end_acc   = gate & (done_rise | tmo_hit);

  always_ff @(posedge clk) begin
    if (rst) begin
      gate    <= 1'b0;
      tick_q  <= '0;
      timeout <= 1'b0;
    end else if (start_acc) begin
      gate    <= 1'b1;
      tick_q  <= '0;
      timeout <= 1'b0;
    end else if (end_acc) begin
      gate    <= 1'b0;
      timeout <= tmo_hit;
    end else if (gate) begin
      tick_q  <= tick_q + 1'b1;
    end
  end
endmodule

// File: rtl/sst_line_drv.sv
module sst_line_drv
  import sram_st_pkg::*;
#(
  parameter int ROWS = 64,
  parameter int COLS = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_acc,
  input  logic                    end_acc,
  input  logic                    wr_en,
  input  logic [$clog2(ROWS)-1:0] row_addr,
  input  logic [$clog2(COLS)-1:0] col_addr,
  output logic [ROWS-1:0]         wl,
  output logic [COLS-1:0]         ev,
  output logic                    dwl,
  output logic                    eq,
  output logic                    mon_sel
);
  localparam int RAW = $clog2(ROWS);
  localparam int CAW = $clog2(COLS);

  logic [ROWS-1:0] row_dec;
  logic [COLS-1:0] col_dec;
  acc_mode_e       mode;

  assign mode = acc_mode_e'(wr_en);

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_dec[r] = (row_addr == RAW'(r));
  end
  for (genvar c = 0; c < COLS; c++) begin : g_col
    assign col_dec[c] = (col_addr == CAW'(c));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wl      <= '0;
      ev      <= '0;
      dwl     <= 1'b0;
      eq      <= 1'b1;
      mon_sel <= 1'b0;
    end else if (start_acc) begin
      wl      <= row_dec;
      ev      <= (mode == MODE_WRITE) ? col_dec : '0;
      dwl     <= (mode == MODE_READ);
      eq      <= 1'b0;
      mon_sel <= (mode == MODE_WRITE);
    end else if (end_acc) begin
      wl      <= '0;
      ev      <= '0;
      dwl     <= 1'b0;
      eq      <= 1'b1;
    end
  end
endmodule

// File: rtl/sst_erase_gen.sv
module sst_erase_gen #(
  parameter int ERASE_TICKS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start_acc,
  input  logic wr_en,
  output logic erase
);
  localparam int EW = $clog2(ERASE_TICKS + 1);

  logic [EW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      erase  <= 1'b0;
      left_q <= '0;
    end else if (start_acc) begin
      erase  <= wr_en;
      left_q <= EW'(ERASE_TICKS - 1);
    end else if (erase) begin
      if (left_q == '0) erase <= 1'b0;
      else              left_q <= left_q - 1'b1;
    end
  end
endmodule

// File: rtl/sram_selftime_ctrl.sv
module sram_selftime_ctrl #(
  parameter int ROWS        = 64,
  parameter int COLS        = 8,
  parameter int ERASE_TICKS = 4,
  parameter int TMO_TICKS   = 256
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cyc_start,
  input  logic                    wr_en,
  input  logic [$clog2(ROWS)-1:0] row_addr,
  input  logic [$clog2(COLS)-1:0] col_addr,
  input  logic                    done_in,
  output logic                    gate,
  output logic                    gate_n,
  output logic                    eq,
  output logic [COLS-1:0]         ev,
  output logic [ROWS-1:0]         wl,
  output logic                    dwl,
  output logic                    erase,
  output logic                    mon_sel,
  output logic                    timeout
);
  logic done_rise;
  logic start_acc;
  logic end_acc;

  sst_done_sync u_sync (
    .clk(clk), .rst(rst), .done_in(done_in), .done_rise(done_rise)
  );

  sst_phase_ctrl #(.TMO_TICKS(TMO_TICKS)) u_phase (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .done_rise(done_rise),
    .gate(gate), .start_acc(start_acc), .end_acc(end_acc), .timeout(timeout)
  );

  sst_line_drv #(.ROWS(ROWS), .COLS(COLS)) u_lines (
    .clk(clk), .rst(rst), .start_acc(start_acc), .end_acc(end_acc),
    .wr_en(wr_en), .row_addr(row_addr), .col_addr(col_addr),
    .wl(wl), .ev(ev), .dwl(dwl), .eq(eq), .mon_sel(mon_sel)
  );

  sst_erase_gen #(.ERASE_TICKS(ERASE_TICKS)) u_erase (
    .clk(clk), .rst(rst), .start_acc(start_acc), .wr_en(wr_en), .erase(erase)
  );

  assign gate_n = ~gate;
endmodule

// File: rtl/sram_selftime_ctrl_chk.sv
module sram_selftime_ctrl_chk #(
  parameter int ROWS        = 64,
  parameter int COLS        = 8,
  parameter int ERASE_TICKS = 4,
  parameter int TMO_TICKS   = 256
) (
  input logic            clk,
  input logic            rst,
  input logic            gate,
  input logic            eq,
  input logic [COLS-1:0] ev,
  input logic [ROWS-1:0] wl,
  input logic            dwl,
  input logic            erase,
  input logic            mon_sel,
  input logic            timeout
);
  localparam int HW = $clog2(TMO_TICKS + 2);

  logic [HW-1:0] high_cnt;

  always_ff @(posedge clk) begin
    if (rst || !gate) high_cnt <= '0;
    else              high_cnt <= high_cnt + 1'b1;
  end

  a_r2_eq_opposes_gate: assert property (@(posedge clk) disable iff (rst)
    eq == !gate);
  a_r3_wl_onehot0: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wl));
  a_r3_write_no_dummy: assert property (@(posedge clk) disable iff (rst)
    (gate && mon_sel) |-> !dwl);
  a_r4_read_no_ev: assert property (@(posedge clk) disable iff (rst)
    (gate && !mon_sel) |-> (ev == '0 && dwl));
  a_r5_mode_held: assert property (@(posedge clk) disable iff (rst)
    gate |=> $stable(mon_sel));
  a_r6_erase_write_only: assert property (@(posedge clk) disable iff (rst)
    erase |-> mon_sel);
  a_r7_idle_lines_off: assert property (@(posedge clk) disable iff (rst)
    !gate |-> (wl == '0 && ev == '0 && !dwl));
  a_r8_eval_bounded: assert property (@(posedge clk) disable iff (rst)
    gate |-> (high_cnt < HW'(TMO_TICKS)));
  a_r8_timeout_idle: assert property (@(posedge clk) disable iff (rst)
    timeout |-> !gate);
endmodule

bind sram_selftime_ctrl sram_selftime_ctrl_chk #(
  .ROWS(ROWS), .COLS(COLS), .ERASE_TICKS(ERASE_TICKS), .TMO_TICKS(TMO_TICKS)
) chk_i (
  .clk(clk), .rst(rst), .gate(gate), .eq(eq), .ev(ev), .wl(wl), .dwl(dwl),
  .erase(erase), .mon_sel(mon_sel), .timeout(timeout)
);

// File: tb/sram_selftime_ctrl_tb.sv
module sram_selftime_ctrl_tb_top;
  localparam int CLK_P = 10;
  localparam int ROWS  = 8;
  localparam int COLS  = 4;
  localparam int ETK   = 3;
  localparam int TMO   = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cyc_start = 1'b0;
  logic wr_en = 1'b0;
  logic [$clog2(ROWS)-1:0] row_addr = '0;
  logic [$clog2(COLS)-1:0] col_addr = '0;
  logic done_in = 1'b0;
  logic gate, gate_n, eq, dwl, erase, mon_sel, timeout;
  logic [COLS-1:0] ev;
  logic [ROWS-1:0] wl;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  sram_selftime_ctrl #(.ROWS(ROWS), .COLS(COLS), .ERASE_TICKS(ETK), .TMO_TICKS(TMO)) dut_i (
    .clk(clk), .rst(rst), .cyc_start(cyc_start), .wr_en(wr_en),
    .row_addr(row_addr), .col_addr(col_addr), .done_in(done_in),
    .gate(gate), .gate_n(gate_n), .eq(eq), .ev(ev), .wl(wl), .dwl(dwl),
    .erase(erase), .mon_sel(mon_sel), .timeout(timeout)
  );

  function automatic longint exp_wl(input bit act, input int row);
    return act ? (longint'(1) << row) : 0;
  endfunction

  function automatic longint exp_ev(input bit act, input bit wr, input int col);
    return (act && wr) ? (longint'(1) << col) : 0;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // d < 0: no completion; otherwise done_in rises at negedge d after the start edge
  task automatic run_access(input bit wr, input int row, input int col, input int d);
    int endj;
    int ecnt;
    endj = (d >= 0) ? d + 3 : TMO;
    ecnt = 0;
    cyc_start = 1'b1; wr_en = wr; row_addr = row[$clog2(ROWS)-1:0]; col_addr = col[$clog2(COLS)-1:0];
    @(negedge clk);
    cyc_start = 1'b0;
    for (int j = 0; j <= endj + 4; j++) begin
      bit eg;
      if (j > 0) @(negedge clk);
      eg = (j < endj);
      chk("R7/R8", "gate", gate, eg);
      chk("R2", "gate_n", gate_n, !eg);
      chk("R2", "eq", eq, !eg);
      chk(wr ? "R3" : "R4", "wl", wl, exp_wl(eg, row));
      chk(wr ? "R3" : "R4", "ev", ev, exp_ev(eg, wr, col));
      chk(wr ? "R3" : "R4", "dwl", dwl, eg && !wr);
      chk("R5", "mon_sel", mon_sel, wr);
      if (j == 0) chk("R6", "erase at start", erase, wr);
      if (j == endj) chk("R8", "timeout flag", timeout, d < 0);
      if (erase) ecnt++;
      // drive after sampling
      if (j == 0) begin
        wr_en = $urandom % 2; row_addr = $urandom % ROWS; col_addr = $urandom % COLS;
      end
      if (j == 1) cyc_start = 1'b1;  // R9: strobe while busy
      if (j == 2) cyc_start = 1'b0;
      if (j == d) done_in = 1'b1;
      if (j == d + 2) done_in = 1'b0;
    end
    chk("R6", "erase width", ecnt, wr ? ETK : 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "gate", gate, 0);
    chk("R1", "gate_n", gate_n, 1);
    chk("R1", "eq", eq, 1);
    chk("R1", "wl", wl, 0);
    chk("R1", "ev", ev, 0);
    chk("R1", "dwl", dwl, 0);
    chk("R1", "erase", erase, 0);
    chk("R1", "timeout", timeout, 0);

    run_access(1'b1, 0, 0, 0);
    run_access(1'b0, ROWS-1, COLS-1, TMO-3);   // completion and limit coincide
    run_access(1'b1, 3, 2, -1);                // R8 timeout
    // R9: completion while idle
    done_in = 1'b1;
    repeat (2) @(negedge clk);
    done_in = 1'b0;
    repeat (6) begin
      @(negedge clk);
      chk("R9", "idle gate", gate, 0);
      chk("R9", "idle eq", eq, 1);
      chk("R9", "idle wl", wl, 0);
      chk("R9", "idle erase", erase, 0);
      chk("R8", "timeout held", timeout, 1);
    end
    run_access(1'b0, 5, 1, 4);
    run_access(1'b1, ROWS-1, COLS-1, -1);

    for (int n = 0; n < 40; n++) begin
      int d;
      d = ($urandom % 5 == 0) ? -1 : int'($urandom % 12);
      run_access(bit'($urandom % 2), int'($urandom % ROWS), int'($urandom % COLS), d);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule